// File: doc/BRIEF.md
# Receive Byte FIFO with Break Overwrite

This block buffers received bytes between a serial deserializer and a register read port. The receiver pushes bytes with a strobe. A line-break event pushes a zero byte and latches a break-change flag. A read of the data register pops the oldest byte. The queue holds four bytes.

When the queue is already full, a new byte is not dropped. It replaces the newest entry, and the count stays at four. Reading an empty queue returns zero and changes nothing. The block also provides three other outputs:
- a ready flag, set while any data is held;
- a full flag;
- an accept output that the serial side uses for flow control.

Top module: `rxbyte_fifo`

## Requirements
- R1: Bytes leave in arrival order. `popData` shows the oldest held byte in the same cycle as `popReq`. The queue advances at the clock edge that samples `popReq`.
- R2: `rxReady` is 1 whenever at least one byte is held. `fifoFull` is 1 exactly when 4 bytes are held. Both change at the clock edge that accepts a push or pop.
- R3: A push or break while 4 bytes are held, with no accepted pop in that cycle, replaces the newest entry. The count stays at 4.
- R4: A `breakEvent` pushes the byte 0x00 and sets `breakFlag`. If `pushValid` is high in the same cycle, the break wins and `pushData` is discarded.
- R5: `breakFlag` stays at 1 until `breakClear` is pulsed. A `breakEvent` in the same cycle as `breakClear` leaves it at 1.
- R6: A `popReq` while empty gives `popData` = 0x00 and leaves the contents and flags unchanged.
- R7: `canAccept` is 1 only when `rxEnable` is 1 and `fifoFull` is 0.
- R8: `rxReset` empties the queue and clears `rxReady` and `fifoFull`. It overrides a push or pop in the same cycle and leaves `breakFlag` untouched.
- R9: An accepted push and pop in the same cycle leave the count unchanged and keep byte order.
- R10: After `rst_n` is released, the queue is empty and `rxReady`, `fifoFull` and `breakFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receiver enabled; gates `canAccept` |
| pushValid | input | 1 | Push strobe for `pushData` |
| pushData | input | WIDTH | Received byte |
| breakEvent | input | 1 | Line-break event; pushes a zero byte |
| popReq | input | 1 | Data register read strobe |
| rxReset | input | 1 | Receiver reset; flushes the queue |
| breakClear | input | 1 | Clears `breakFlag` |
| popData | output | WIDTH | Oldest byte, or 0 when empty |
| rxReady | output | 1 | At least one byte held |
| fifoFull | output | 1 | Four bytes held |
| breakFlag | output | 1 | Sticky break-change flag |
| canAccept | output | 1 | Flow-control accept |

## Verification
The results of this block fall due at different times:
- `popData` is combinational from the stored head. It is due in the same cycle as the read strobe, so the bench samples it one time unit after driving the inputs, before the clock edge.
- `rxReady`, `fifoFull`, `breakFlag` and `canAccept` all follow registered state. They are due one edge after the stimulus, so the bench samples them on the following falling edge.

A bench model applies the same rules in order: reset first, then pop, then push or overwrite. That order yields the expected value for each of those two sample points.

// File: rtl/rxbyte_fifo_pkg.sv
package rxbyte_fifo_pkg;
  typedef struct packed {
    logic flush;     // empty the queue
    logic read;      // advance the read pointer
    logic write;     // store the incoming byte
    logic overwrite; // store over the newest entry instead of appending
    logic zeroData;  // stored byte is 0x00 (break)
  } fifoCtl_t;
endpackage

// File: rtl/rxbyte_fifo_ctrl.sv
module rxbyte_fifo_ctrl
  import rxbyte_fifo_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rxEnable,
  input  logic     pushValid,
  input  logic     breakEvent,
  input  logic     popReq,
  input  logic     rxReset,
  input  logic     breakClear,
  output fifoCtl_t ctl,
  output logic     rxReady,
  output logic     fifoFull,
  output logic     breakFlag,
  output logic     canAccept
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic doPop, doIn, isFull, isEmpty;

  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);
  assign doPop   = popReq && !isEmpty && !rxReset;
  assign doIn    = (pushValid || breakEvent) && !rxReset;

  always_comb begin
    ctl           = '0;
    ctl.flush     = rxReset;
    ctl.read      = doPop;
    ctl.write     = doIn;
    ctl.overwrite = doIn && isFull && !doPop;
    ctl.zeroData  = breakEvent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (ctl.flush) begin
      count <= '0;
    end else begin
      if (ctl.write && !ctl.overwrite && !ctl.read)
        count <= count + CNT_W'(1);
      else if (ctl.read && !ctl.write)
        count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          breakFlag <= 1'b0;
    else if (breakEvent) breakFlag <= 1'b1;
    else if (breakClear) breakFlag <= 1'b0;
  end

  assign rxReady   = !isEmpty;
  assign fifoFull  = isFull;
  assign canAccept = rxEnable && !isFull;
endmodule

// File: rtl/rxbyte_fifo_dp.sv
module rxbyte_fifo_dp
  import rxbyte_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fifoCtl_t         ctl,
  input  logic             hasData,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] popData
);
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr, newestPtr;
  logic [WIDTH-1:0] inByte;

  function automatic logic [PTR_W-1:0] incPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] decPtr(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - PTR_W'(1);
  endfunction

  assign inByte    = ctl.zeroData ? '0 : pushData;
  assign newestPtr = decPtr(wrPtr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else if (ctl.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (ctl.read) rdPtr <= incPtr(rdPtr);
      if (ctl.write && !ctl.overwrite) wrPtr <= incPtr(wrPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (!ctl.flush && ctl.write) begin
      if (ctl.overwrite) mem[newestPtr] <= inByte;
      else               mem[wrPtr]     <= inByte;
    end
  end

  assign popData = hasData ? mem[rdPtr] : '0;
endmodule

// File: rtl/rxbyte_fifo.sv
module rxbyte_fifo
  import rxbyte_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxEnable,
  input  logic             pushValid,
  input  logic [WIDTH-1:0] pushData,
  input  logic             breakEvent,
  input  logic             popReq,
  input  logic             rxReset,
  input  logic             breakClear,
  output logic [WIDTH-1:0] popData,
  output logic             rxReady,
  output logic             fifoFull,
  output logic             breakFlag,
  output logic             canAccept
);
  fifoCtl_t ctl;

  rxbyte_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .pushValid(pushValid),
    .breakEvent(breakEvent), .popReq(popReq), .rxReset(rxReset),
    .breakClear(breakClear), .ctl(ctl), .rxReady(rxReady),
    .fifoFull(fifoFull), .breakFlag(breakFlag), .canAccept(canAccept)
  );

  rxbyte_fifo_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .hasData(rxReady),
    .pushData(pushData), .popData(popData)
  );
endmodule

// File: rtl/rxbyte_fifo_chk.sv
module rxbyte_fifo_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rxEnable,
  input logic             pushValid,
  input logic             breakEvent,
  input logic             popReq,
  input logic             rxReset,
  input logic             breakClear,
  input logic [WIDTH-1:0] popData,
  input logic             rxReady,
  input logic             fifoFull,
  input logic             breakFlag,
  input logic             canAccept
);
  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fifoFull |-> rxReady); // R2
  AST_FULL_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifoFull) |-> $past(pushValid || breakEvent)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fifoFull && (pushValid || breakEvent) && !popReq && !rxReset |=> fifoFull); // R3
  AST_BREAK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    breakEvent |=> breakFlag); // R4
  AST_BREAK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    breakClear && !breakEvent |=> !breakFlag); // R5
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rxReady |-> popData == '0); // R6
  AST_EMPTY_POP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    popReq && !rxReady && !pushValid && !breakEvent |=> !rxReady); // R6
  AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    canAccept |-> rxEnable && !fifoFull); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rxReset |=> !rxReady && !fifoFull); // R8
endmodule

bind rxbyte_fifo rxbyte_fifo_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .pushValid(pushValid),
  .breakEvent(breakEvent), .popReq(popReq), .rxReset(rxReset),
  .breakClear(breakClear), .popData(popData), .rxReady(rxReady),
  .fifoFull(fifoFull), .breakFlag(breakFlag), .canAccept(canAccept)
);

// File: tb/rxbyte_fifo_tb_top.sv
module rxbyte_fifo_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxEnable = 1'b0, pushValid = 1'b0, breakEvent = 1'b0;
  logic popReq = 1'b0, rxReset = 1'b0, breakClear = 1'b0;
  logic [W-1:0] pushData = '0;
  logic [W-1:0] popData;
  logic rxReady, fifoFull, breakFlag, canAccept;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [W-1:0] mq [4];
  int mcnt = 0;
  bit mbrk = 0;

  always #4 clk = ~clk;

  rxbyte_fifo #(.DEPTH(4), .WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .pushValid(pushValid),
    .pushData(pushData), .breakEvent(breakEvent), .popReq(popReq),
    .rxReset(rxReset), .breakClear(breakClear), .popData(popData),
    .rxReady(rxReady), .fifoFull(fifoFull), .breakFlag(breakFlag),
    .canAccept(canAccept)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] modelHead();
    return (mcnt == 0) ? '0 : mq[0];
  endfunction

  // Model: reset first, then pop, then push/overwrite.
  task automatic modelStep(input bit psh, input logic [W-1:0] d, input bit brk,
                           input bit pop, input bit rst, input bit clr);
    logic [W-1:0] v;
    if (brk) mbrk = 1;
    else if (clr) mbrk = 0;
    if (rst) begin
      mcnt = 0;
      return;
    end
    if (pop && mcnt > 0) begin
      for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (psh || brk) begin
      v = brk ? '0 : d;
      if (mcnt == 4) mq[3] = v;
      else begin
        mq[mcnt] = v;
        mcnt++;
      end
    end
  endtask

  // Called at a falling edge; drives, checks popData, clocks, checks flags.
  task automatic step(input string tag, input bit en, input bit psh, input logic [W-1:0] d,
                      input bit brk, input bit pop, input bit rst, input bit clr);
    rxEnable = en; pushValid = psh; pushData = d; breakEvent = brk;
    popReq = pop; rxReset = rst; breakClear = clr;
    #1;
    if (pop) check({tag, " R1/R6 popData"}, popData, modelHead());
    @(posedge clk);
    modelStep(psh, d, brk, pop, rst, clr);
    @(negedge clk);
    check({tag, " R2 rxReady"}, W'(rxReady), W'(mcnt != 0));
    check({tag, " R2 fifoFull"}, W'(fifoFull), W'(mcnt == 4));
    check({tag, " R5 breakFlag"}, W'(breakFlag), W'(mbrk));
    check({tag, " R7 canAccept"}, W'(canAccept), W'(en && mcnt != 4));
  endtask

  task automatic idle();
    step("idle", rxEnable, 0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 rxReady", W'(rxReady), '0);
    check("R10 fifoFull", W'(fifoFull), '0);
    check("R10 breakFlag", W'(breakFlag), '0);
    check("R10 popData", popData, '0);

    // R6 pop while empty
    step("R6 empty pop", 1, 0, '0, 0, 1, 0, 0);

    // R1 order, R2 fill to full
    step("R1 p1", 1, 1, 8'h11, 0, 0, 0, 0);
    step("R1 p2", 1, 1, 8'h22, 0, 0, 0, 0);
    step("R1 p3", 1, 1, 8'h33, 0, 0, 0, 0);
    step("R2 p4", 1, 1, 8'h44, 0, 0, 0, 0);
    // R3 overwrite newest while full
    step("R3 ovw", 1, 1, 8'h55, 0, 0, 0, 0);
    // R4 break while full overwrites, break wins over push
    step("R4 brk", 1, 1, 8'hAA, 1, 0, 0, 0);
    // R9 push+pop while full
    step("R9 pp full", 1, 1, 8'h66, 0, 1, 0, 0);
    step("R1 drain", 1, 0, '0, 0, 1, 0, 0);
    step("R1 drain", 1, 0, '0, 0, 1, 0, 0);
    // R5 clear with break in same cycle keeps flag
    step("R5 clr+brk", 1, 0, '0, 1, 0, 0, 1);
    step("R5 clr", 1, 0, '0, 0, 0, 0, 1);
    // R8 reset overrides push and pop, breakFlag untouched
    step("R4 brk2", 1, 0, '0, 1, 0, 0, 0);
    step("R8 flush", 1, 1, 8'h77, 0, 1, 1, 0);
    step("R6 after flush", 0, 0, '0, 0, 1, 0, 0);
    // R9 push+pop while empty: pop ignored, push lands
    step("R9 pp empty", 1, 1, 8'h88, 0, 1, 0, 0);
    step("R9 pop", 1, 0, '0, 0, 1, 0, 0);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      bit en, psh, brk, pop, rst, clr;
      en  = ($urandom % 4) != 0;
      psh = ($urandom % 2) != 0;
      brk = ($urandom % 12) == 0;
      pop = ($urandom % 5) < 2;
      rst = ($urandom % 40) == 0;
      clr = ($urandom % 8) == 0;
      step("rand", en, psh, W'($urandom), brk, pop, rst, clr);
    end
    idle();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule